// File: doc/BRIEF.md
# Link-Register Program Sequencer with Interrupt Gate

This block holds the program counter of a small processor that keeps the return address of a call in a single link register rather than in a hardware return stack. Every instruction word whose most significant bit is clear is a jump: the remaining fifteen bits are the target, and the address after the jump is copied into the link register. Calls and plain jumps therefore share one encoding. A routine that does not return simply ignores the link. A routine that calls further routines must first move the link into a working register through the explicit read and write strobes. Only one return level lives in hardware, and software builds any deeper stack.

Interrupts return through a separate interrupt-return register, so they never disturb the link register. The block still closes the interrupt gate for the single instruction that follows a jump. That instruction is the one that saves the link. It also keeps further interrupts out until the handler executes its return-from-interrupt instruction. An accepted interrupt discards the instruction presented in that cycle, and that instruction is fetched again when the handler returns.

Top module: `link_branch_gate`

## Requirements
- R1: After reset the PC, the link register and the interrupt-return register are all 0, and the gate is open, so an interrupt can be accepted on the first executed cycle.
- R2: An executed instruction with bit 15 = 0 loads the PC with bits 14:0 and loads the link register with the old PC + 1, modulo 2^15 (so 0x7FFF links to 0).
- R3: An executed instruction with bit 15 = 1 and bits 14:12 other than 000 or 001 advances the PC by 1 modulo 2^15.
- R4: An executed instruction with bit 15 = 1 and bits 14:12 = 000 (return) loads the PC from the link register as it was before that cycle and leaves the link register unchanged.
- R5: An interrupt is accepted in a cycle with instr_valid = 1 and irq_req = 1 while the gate is open. In that cycle irq_ack is 1, the interrupt-return register takes the current PC, the PC takes the vector IRQ_VEC (default 0x4000), and the presented instruction is not executed.
- R6: The executed instruction directly after a jump cannot be preempted: irq_ack stays 0 in that cycle even when irq_req is 1.
- R7: After an acceptance no further interrupt is accepted until an instruction with bit 15 = 1 and bits 14:12 = 001 executes. That instruction loads the PC from the interrupt-return register and reopens the gate.
- R8: lr_wr = 1 loads the link register from lr_wdata unless a jump executes in the same cycle, in which case the jump's link value wins.
- R9: lr_rdata shows the link register while lr_rd = 1 and reads 0 otherwise.
- R10: fetch_addr always equals the PC value that holds after the next clock edge.
- R11: In a cycle with instr_valid = 0 the PC, the interrupt-return register and the gate state stay unchanged, and irq_ack is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction executes at the current PC this cycle |
| instr | input | 16 | Instruction word being executed |
| irq_req | input | 1 | Interrupt request level |
| lr_wr | input | 1 | Load the link register from lr_wdata |
| lr_wdata | input | 15 | Value for an explicit link-register load |
| lr_rd | input | 1 | Explicit link-register read strobe |
| pc_o | output | 15 | Current program counter |
| lr_o | output | 15 | Current link register |
| lr_rdata | output | 15 | Link register while lr_rd is set, else 0 |
| ilr_o | output | 15 | Interrupt-return register |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| fetch_addr | output | 15 | Next fetch address |

## Verification
Two functions can land in the same cycle. The first is an interrupt request arriving on the instruction just after a jump, where the gate must refuse it. The second is an explicit link-register load that coincides with a jump or with an accepted interrupt, where the jump's link value must win and the accepted interrupt must let the load through. Directed cases force both collisions, including a jump at 0x7FFF to test wrap-around. Random streams mix these strobes with requests at a high rate. Each cycle is judged against a bench model of the PC, link, interrupt-return register and gate, derived from the requirements.

// File: rtl/lbg_pkg.sv
package lbg_pkg;

    typedef enum logic [2:0] {
        CLS_JUMP,
        CLS_RET,
        CLS_RETI,
        CLS_SEQ
    } instr_cls_e;

    localparam logic [2:0] OP_RET  = 3'b000;
    localparam logic [2:0] OP_RETI = 3'b001;

endpackage

// File: rtl/lbg_decode.sv
module lbg_decode
    import lbg_pkg::*;
#(
    parameter int IW = 16,
    localparam int AW = IW - 1
) (
    input  logic [IW-1:0] instr,
    output instr_cls_e    cls,
    output logic [AW-1:0] target
);

    logic [2:0] op_field;

    always_comb begin
        op_field = instr[IW-2 -: 3];
        target   = instr[AW-1:0];
        if (!instr[IW-1]) begin
            cls = CLS_JUMP;
        end else begin
            case (op_field)
                OP_RET:  cls = CLS_RET;
                OP_RETI: cls = CLS_RETI;
                default: cls = CLS_SEQ;
            endcase
        end
    end

endmodule

// File: rtl/lbg_irq_gate.sv
module lbg_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic irq_req,
    input  logic is_jump,
    input  logic is_reti,
    output logic accept
);

    typedef struct packed {
        logic shadow;
        logic in_isr;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        accept = instr_valid && irq_req && !gate_q.shadow && !gate_q.in_isr;
        if (accept) begin
            gate_d.in_isr = 1'b1;
        end else if (instr_valid) begin
            gate_d.shadow = is_jump;
            if (is_reti) begin
                gate_d.in_isr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    AST_SHADOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && is_jump && !accept) |=> !accept); // R6

    AST_ISR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept); // R7

    AST_NO_ACK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !accept); // R11

endmodule

// File: rtl/lbg_seq.sv
module lbg_seq
    import lbg_pkg::*;
#(
    parameter int AW = 15,
    parameter logic [AW-1:0] IRQ_VEC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  instr_cls_e    cls,
    input  logic [AW-1:0] target,
    input  logic          accept,
    input  logic          lr_wr,
    input  logic [AW-1:0] lr_wdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] lr,
    output logic [AW-1:0] ilr,
    output logic [AW-1:0] next_pc
);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] lr;
        logic [AW-1:0] ilr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic jump_exec;
    logic [AW-1:0] pc_inc;

    always_comb begin
        seq_d     = seq_q;
        pc_inc    = seq_q.pc + 1'b1;
        jump_exec = instr_valid && !accept && (cls == CLS_JUMP);
        if (lr_wr && !jump_exec) begin
            seq_d.lr = lr_wdata;
        end
        if (accept) begin
            seq_d.ilr = seq_q.pc;
            seq_d.pc  = IRQ_VEC;
        end else if (instr_valid) begin
            case (cls)
                CLS_JUMP: begin
                    seq_d.pc = target;
                    seq_d.lr = pc_inc;
                end
                CLS_RET:  seq_d.pc = seq_q.lr;
                CLS_RETI: seq_d.pc = seq_q.ilr;
                default:  seq_d.pc = pc_inc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pc      = seq_q.pc;
    assign lr      = seq_q.lr;
    assign ilr     = seq_q.ilr;
    assign next_pc = seq_d.pc;

    AST_JUMP_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
        jump_exec |=> (lr == $past(pc) + 1'b1)); // R2

    AST_RET_KEEPS_LR: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !accept && cls == CLS_RET && !lr_wr) |=> (lr == $past(lr) && pc == $past(lr))); // R4

    AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pc == IRQ_VEC && ilr == $past(pc))); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(pc) && $stable(ilr))); // R11

endmodule

// File: rtl/link_branch_gate.sv
module link_branch_gate
    import lbg_pkg::*;
#(
    parameter int IW = 16,
    parameter logic [IW-2:0] IRQ_VEC = 15'h4000,
    localparam int AW = IW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [IW-1:0] instr,
    input  logic          irq_req,
    input  logic          lr_wr,
    input  logic [AW-1:0] lr_wdata,
    input  logic          lr_rd,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] lr_o,
    output logic [AW-1:0] lr_rdata,
    output logic [AW-1:0] ilr_o,
    output logic          irq_ack,
    output logic [AW-1:0] fetch_addr
);

    instr_cls_e    cls;
    logic [AW-1:0] target;
    logic          accept;

    lbg_decode #(.IW(IW)) u_decode (
        .instr  (instr),
        .cls    (cls),
        .target (target)
    );

    lbg_irq_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .irq_req     (irq_req),
        .is_jump     (cls == CLS_JUMP),
        .is_reti     (cls == CLS_RETI),
        .accept      (accept)
    );

    lbg_seq #(.AW(AW), .IRQ_VEC(IRQ_VEC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .cls         (cls),
        .target      (target),
        .accept      (accept),
        .lr_wr       (lr_wr),
        .lr_wdata    (lr_wdata),
        .pc          (pc_o),
        .lr          (lr_o),
        .ilr         (ilr_o),
        .next_pc     (fetch_addr)
    );

    assign irq_ack  = accept;
    assign lr_rdata = lr_rd ? lr_o : '0;

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (irq_req && instr_valid)); // R5

    AST_FETCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pc_o == $past(fetch_addr))); // R10

    AST_RDATA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !lr_rd |-> (lr_rdata == '0)); // R9

endmodule

// File: tb/test_link_branch_gate.sv
`timescale 1ns/1ps
module test_link_branch_gate;

    localparam logic [14:0] VEC = 15'h4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'hF000;
    logic        irq_req = 1'b0;
    logic        lr_wr = 1'b0;
    logic [14:0] lr_wdata = '0;
    logic        lr_rd = 1'b0;
    logic [14:0] pc_o, lr_o, lr_rdata, ilr_o, fetch_addr;
    logic        irq_ack;

    int n_checks = 0;
    int n_fail = 0;

    // model state
    logic [14:0] m_pc = '0, m_lr = '0, m_ilr = '0;
    logic        m_shadow = 1'b0, m_isr = 1'b0;

    always #2.5 clk = ~clk;

    link_branch_gate i_link_branch_gate (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .irq_req(irq_req), .lr_wr(lr_wr), .lr_wdata(lr_wdata), .lr_rd(lr_rd),
        .pc_o(pc_o), .lr_o(lr_o), .lr_rdata(lr_rdata), .ilr_o(ilr_o),
        .irq_ack(irq_ack), .fetch_addr(fetch_addr)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_accept();
        return instr_valid && irq_req && !m_shadow && !m_isr;
    endfunction

    // next-state model from the requirements
    function automatic void model_step();
        logic acc = exp_accept();
        logic jmp = instr_valid && !acc && !instr[15];
        logic [14:0] old_lr = m_lr;
        if (lr_wr && !jmp) m_lr = lr_wdata;           // R8
        if (acc) begin                                  // R5
            m_ilr = m_pc; m_pc = VEC; m_isr = 1'b1;
        end else if (instr_valid) begin
            m_shadow = jmp;                             // R6
            if (!instr[15]) begin                       // R2
                m_lr = m_pc + 15'd1; m_pc = instr[14:0];
            end else if (instr[14:12] == 3'b000) begin  // R4
                m_pc = old_lr;
            end else if (instr[14:12] == 3'b001) begin  // R7
                m_pc = m_ilr; m_isr = 1'b0;
            end else begin                              // R3
                m_pc = m_pc + 15'd1;
            end
        end                                             // else R11: hold
    endfunction

    // one cycle: inputs applied at negedge, comb checks, edge, reg checks
    task automatic step(logic v, logic [15:0] w, logic irq, logic wr, logic [14:0] wd, logic rd, string tag);
        logic [14:0] exp_next;
        instr_valid = v; instr = w; irq_req = irq; lr_wr = wr; lr_wdata = wd; lr_rd = rd;
        #1;
        check({tag, " ack R5/R6/R7/R11"}, irq_ack, exp_accept());
        check("R9 lr_rdata", lr_rdata, rd ? m_lr : 15'd0);
        model_step();
        exp_next = m_pc;
        check("R10 fetch_addr", fetch_addr, exp_next);
        @(posedge clk); @(negedge clk);
        check({tag, " pc"}, pc_o, m_pc);
        check({tag, " lr"}, lr_o, m_lr);
        check({tag, " ilr"}, ilr_o, m_ilr);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 pc", pc_o, 15'd0);
        check("R1 lr", lr_o, 15'd0);
        check("R1 ilr", ilr_o, 15'd0);
        // R1: gate open on first executed cycle
        step(1, 16'hF000, 1, 0, 0, 0, "R1 first irq");
        check("R1 ack vector", pc_o, VEC);
        step(1, 16'h9000, 0, 0, 0, 0, "R7 reti");        // back to 0
        // R2 jump and R6 shadow
        step(1, 16'h0123, 0, 0, 0, 1, "R2 jump");
        check("R2 link", lr_o, 15'd1);
        step(1, 16'hF000, 1, 0, 0, 1, "R6 shadow");
        step(1, 16'hF000, 1, 0, 0, 0, "R5 after shadow");
        // R7 masked in handler
        step(1, 16'hF000, 1, 0, 0, 0, "R7 masked");
        step(1, 16'h9000, 0, 0, 0, 0, "R7 reti2");
        // R4 return
        step(1, 16'h8000, 0, 0, 0, 0, "R4 ret");
        // R2 wrap: jump to 0x7FFF then jump from there
        step(1, 16'h7FFF, 0, 0, 0, 0, "R2 to top");
        step(1, 16'h0050, 0, 0, 0, 0, "R2 wrap");
        check("R2 wrap link", lr_o, 15'd0);
        // R8 collision: jump wins over lr_wr
        step(1, 16'h0200, 0, 1, 15'h1234, 0, "R8 jump wins");
        check("R8 jump wins lr", lr_o, 15'h0051);
        // R8 lr_wr with sequential op
        step(1, 16'hA000, 0, 1, 15'h2222, 1, "R8 load");
        // R8 lr_wr on accepted interrupt cycle
        step(1, 16'h0300, 1, 1, 15'h3333, 0, "R8 on accept");
        step(1, 16'h9000, 0, 0, 0, 0, "reti3");
        // R11 stall
        step(0, 16'h0111, 1, 0, 0, 0, "R11 stall");
        // R3 sequential
        step(1, 16'hC000, 0, 0, 0, 0, "R3 seq");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] w;
            int r = $urandom_range(0, 99);
            if (r < 30) w = {1'b0, 15'($urandom)};
            else if (r < 45) w = 16'h8000 | 16'($urandom_range(0, 4095));
            else if (r < 60) w = 16'h9000 | 16'($urandom_range(0, 4095));
            else w = {1'b1, 3'($urandom_range(2, 7)), 12'($urandom)};
            step($urandom_range(0, 99) < 85, w, $urandom_range(0, 99) < 35,
                 $urandom_range(0, 99) < 12, 15'($urandom), $urandom_range(0, 1) == 1, "rand");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule